// File: doc/BRIEF.md
# Masked Register Poll Unit

This unit carries out the poll instruction of a command sequencer. Once the poll has been handed over, the unit reads one register through a simple request/acknowledge read port. It ANDs the returned word with a mask and compares the result with an expected value under the same mask. If the values differ, it waits a programmed number of microsecond ticks and reads again. It stops when a read matches or when the retry budget is used up. In both cases it releases the sequencer with a one-cycle completion pulse and a pass flag. Running out of retries also sets a sticky error interrupt bit, which software clears by writing 1.

The mask and the poll-function word (enable, wait interval and retry count) are configuration registers that are written before the poll. A new value goes into a staging copy first. It is copied into the active copy only after the sequencer has retired a fixed number of further instructions, normally five no-ops. A poll issued inside that settling gap therefore still runs with the previous settings.

Top module: `mpoll_unit`

## Requirements
- R1: After reset, `busy`, `rd_req`, `done` and `irq_err` are low. The active mask is all ones and the active function word is zero, so polling is disabled.
- R2: A strobe on `ins_valid` starts a poll only when bits 31:24 of `ins_hi` equal 0x0A. Any other opcode produces no read request and no completion.
- R3: `rd_addr` carries bits 19:0 of `ins_hi` from the accepted instruction. It holds steady while a request waits for `rd_ack`.
- R4: A read passes when `(rd_data & mask) == (ins_lo & mask)`. Bits outside the mask never affect the outcome. On a passing read, `done` and `done_ok` go high in the cycle after the acknowledged read.
- R5: If the enable bit (bit 31) of the active function word is clear, an accepted poll produces `done` with `done_ok` high in the next cycle, and no read is issued.
- R6: The function word's count field (bits 7:0) gives N. The unit performs at most N+1 reads. If all of them fail, it raises `done` with `done_ok` low in the cycle after the last acknowledgement.
- R7: After a failed read with budget left, the next request is raised one cycle after the W-th `us_tick`, where W is the wait field (bits 23:16). If W is 0, the next read follows at once.
- R8: Running out of retries sets `irq_err` in the same cycle as the failing `done`. The bit stays set until a cycle with `err_clr` high clears it.
- R9: A configuration write (`cfg_sel` 0 selects the mask, 1 selects the function word) takes effect only after SETTLE (5) `seq_step` pulses. Polls accepted before that use the previous values.
- R10: While `busy` is high, `ins_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = mask register, 1 = poll-function register |
| cfg_wdata | input | 32 | Configuration write data |
| seq_step | input | 1 | One pulse per instruction retired by the sequencer |
| ins_valid | input | 1 | Instruction strobe |
| ins_lo | input | 32 | First instruction word: expected value |
| ins_hi | input | 32 | Second instruction word: opcode [31:24], register offset [19:0] |
| us_tick | input | 1 | One-cycle microsecond tick |
| rd_req | output | 1 | Register read request |
| rd_addr | output | 20 | Register read offset |
| rd_ack | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |
| done | output | 1 | One-cycle poll completion |
| done_ok | output | 1 | Poll outcome, 1 = match, valid with `done` |
| busy | output | 1 | Poll in progress |
| irq_err | output | 1 | Sticky poll-error interrupt status |
| err_clr | input | 1 | Write-1-to-clear strobe for `irq_err` |

## Verification
A wrong retry counter shows at the ports as one read too many or too few, or as a wrong pass flag. This appears within one poll, so the bench sweeps count, wait interval and number of failing reads, and compares the read count and outcome of every poll with arithmetic expectations. A wait counter that is off by one moves the next request by one tick, which the bench detects with tick-by-tick stimulus. A settling counter error lets a poll inside the gap see new settings, so its read count or completion changes immediately.

// File: rtl/mpoll_pkg.sv
package mpoll_pkg;
   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,
      PS_READ = 2'd1,
      PS_WAIT = 2'd2
   } poll_state_e;

   localparam logic [7:0] POLL_OPCODE  = 8'h0A;
   localparam logic       CFG_SEL_MASK = 1'b0;
   localparam logic       CFG_SEL_FUNC = 1'b1;
endpackage

// File: rtl/mpoll_cfg.sv
module mpoll_cfg #(
   parameter int DATA_W = 32,
   parameter int SETTLE = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              seq_step,
   output logic [DATA_W-1:0] act_mask,
   output logic [DATA_W-1:0] act_func
);
   import mpoll_pkg::*;

   localparam int STEP_W = $clog2(SETTLE + 1);
   localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SETTLE - 1);

   logic [DATA_W-1:0] stg_mask, stg_func;
   logic              pend;
   logic [STEP_W-1:0] steps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_mask <= '1;
         stg_func <= '0;
         act_mask <= '1;
         act_func <= '0;
         pend     <= 1'b0;
         steps    <= '0;
      end else if (cfg_we) begin
         if (cfg_sel == CFG_SEL_MASK) stg_mask <= cfg_wdata;
         else                         stg_func <= cfg_wdata;
         pend  <= 1'b1;
         steps <= '0;
      end else if (pend && seq_step) begin
         if (steps == STEP_LAST) begin
            act_mask <= stg_mask;
            act_func <= stg_func;
            pend     <= 1'b0;
            steps    <= '0;
         end else begin
            steps <= steps + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mpoll_match.sv
module mpoll_match #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] expect_v,
   input  logic [DATA_W-1:0] mask,
   output logic              hit
);
   localparam int LANES = DATA_W / LANE_W;

   generate
      if ((DATA_W % LANE_W) == 0 && LANES > 1) begin : g_lanes
         logic [LANES-1:0] lane_eq;
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign lane_eq[i] =
               ((value[i*LANE_W +: LANE_W] ^ expect_v[i*LANE_W +: LANE_W]) &
                mask[i*LANE_W +: LANE_W]) == '0;
         end
         assign hit = &lane_eq;
      end else begin : g_flat
         assign hit = ((value ^ expect_v) & mask) == '0;
      end
   endgenerate
endmodule

// File: rtl/mpoll_ctrl.sv
module mpoll_ctrl #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 20,
   parameter int WAIT_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              enable,
   input  logic [WAIT_W-1:0] wait_iv,
   input  logic [CNT_W-1:0]  retries,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [DATA_W-1:0] ins_exp,
   input  logic [DATA_W-1:0] cur_mask,
   input  logic              us_tick,
   input  logic              rd_ack,
   input  logic              hit,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] exp_q,
   output logic [DATA_W-1:0] mask_q,
   output logic              done,
   output logic              done_ok,
   output logic              busy,
   output logic              exhaust
);
   import mpoll_pkg::*;

   poll_state_e       state;
   logic [CNT_W-1:0]  left;
   logic [WAIT_W-1:0] iv_q, wcnt;

   assign rd_req  = (state == PS_READ);
   assign busy    = (state != PS_IDLE);
   assign exhaust = rd_req && rd_ack && !hit && (left == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= PS_IDLE;
         left    <= '0;
         iv_q    <= '0;
         wcnt    <= '0;
         rd_addr <= '0;
         exp_q   <= '0;
         mask_q  <= '0;
         done    <= 1'b0;
         done_ok <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            PS_IDLE: begin
               if (start) begin
                  if (!enable) begin
                     done    <= 1'b1;
                     done_ok <= 1'b1;
                  end else begin
                     rd_addr <= ins_addr;
                     exp_q   <= ins_exp;
                     mask_q  <= cur_mask;
                     left    <= retries;
                     iv_q    <= wait_iv;
                     state   <= PS_READ;
                  end
               end
            end
            PS_READ: begin
               if (rd_ack) begin
                  if (hit) begin
                     done    <= 1'b1;
                     done_ok <= 1'b1;
                     state   <= PS_IDLE;
                  end else if (left == '0) begin
                     done    <= 1'b1;
                     done_ok <= 1'b0;
                     state   <= PS_IDLE;
                  end else begin
                     left <= left - 1'b1;
                     if (iv_q != '0) begin
                        wcnt  <= iv_q;
                        state <= PS_WAIT;
                     end
                  end
               end
            end
            PS_WAIT: begin
               if (us_tick) begin
                  if (wcnt == WAIT_W'(1)) state <= PS_READ;
                  wcnt <= wcnt - 1'b1;
               end
            end
            default: state <= PS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mpoll_unit.sv
module mpoll_unit #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 20,
   parameter int WAIT_W   = 8,
   parameter int CNT_W    = 8,
   parameter int WAIT_LSB = 16,
   parameter int SETTLE   = 5,
   parameter int LANE_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              seq_step,
   input  logic              ins_valid,
   input  logic [DATA_W-1:0] ins_lo,
   input  logic [DATA_W-1:0] ins_hi,
   input  logic              us_tick,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              done_ok,
   output logic              busy,
   output logic              irq_err,
   input  logic              err_clr
);
   import mpoll_pkg::*;

   localparam int OPC_LSB = DATA_W - 8;
   localparam int EN_BIT  = DATA_W - 1;

   generate
      if (DATA_W < 32) begin : g_bad_data
         $error("mpoll_unit: DATA_W must be at least 32");
      end
      if (ADDR_W > OPC_LSB) begin : g_bad_addr
         $error("mpoll_unit: ADDR_W overlaps the opcode field");
      end
      if (CNT_W > WAIT_LSB || WAIT_LSB + WAIT_W > EN_BIT) begin : g_bad_func
         $error("mpoll_unit: function word fields overlap");
      end
      if (SETTLE < 1) begin : g_bad_settle
         $error("mpoll_unit: SETTLE must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] act_mask, act_func, exp_q, mask_q;
   logic              start, hit, exhaust;

   mpoll_cfg #(.DATA_W(DATA_W), .SETTLE(SETTLE)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .seq_step(seq_step),
      .act_mask(act_mask), .act_func(act_func)
   );

   assign start = ins_valid && (ins_hi[OPC_LSB +: 8] == POLL_OPCODE);

   mpoll_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .enable(act_func[EN_BIT]),
      .wait_iv(act_func[WAIT_LSB +: WAIT_W]),
      .retries(act_func[0 +: CNT_W]),
      .ins_addr(ins_hi[ADDR_W-1:0]), .ins_exp(ins_lo), .cur_mask(act_mask),
      .us_tick(us_tick), .rd_ack(rd_ack), .hit(hit),
      .rd_req(rd_req), .rd_addr(rd_addr), .exp_q(exp_q), .mask_q(mask_q),
      .done(done), .done_ok(done_ok), .busy(busy), .exhaust(exhaust)
   );

   mpoll_match #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_match (
      .value(rd_data), .expect_v(exp_q), .mask(mask_q), .hit(hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_err <= 1'b0;
      else if (exhaust) irq_err <= 1'b1;
      else if (err_clr) irq_err <= 1'b0;
   end

   logic unused_bits;
   assign unused_bits = ^{ins_hi[OPC_LSB-1:ADDR_W], act_func};
endmodule

// File: rtl/mpoll_unit_chk.sv
module mpoll_unit_chk #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req,
   input logic              rd_ack,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              busy,
   input logic              done,
   input logic              done_ok,
   input logic              irq_err,
   input logic              err_clr
);
   a_r1_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> busy);

   a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r8_irq_on_exhaust: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_err) |-> (done && !done_ok));

   a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_err && !err_clr) |=> irq_err);
endmodule

bind mpoll_unit mpoll_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
   .rd_addr(rd_addr), .busy(busy), .done(done), .done_ok(done_ok),
   .irq_err(irq_err), .err_clr(err_clr)
);

// File: tb/sim_mpoll_unit.sv
`timescale 1ns/1ps
module sim_mpoll_unit;
   logic        clk = 0, rst_n = 0;
   logic        cfg_we = 0, cfg_sel = 0, seq_step = 0, ins_valid = 0;
   logic [31:0] cfg_wdata = 0, ins_lo = 0, ins_hi = 0, rd_data = 0;
   logic        us_tick = 0, rd_ack = 0, err_clr = 0;
   logic        rd_req, done, done_ok, busy, irq_err;
   logic [19:0] rd_addr;

   int n_tests = 0, n_fail = 0, addr_err = 0;

   always #4 clk = ~clk;

   mpoll_unit u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .seq_step(seq_step), .ins_valid(ins_valid),
      .ins_lo(ins_lo), .ins_hi(ins_hi), .us_tick(us_tick), .rd_req(rd_req),
      .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .done(done),
      .done_ok(done_ok), .busy(busy), .irq_err(irq_err), .err_clr(err_clr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic cfg_write(input logic sel, input logic [31:0] d);
      @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); seq_step = 1;
      end
      @(negedge clk); seq_step = 0;
   endtask

   function automatic logic [31:0] fword(input int iv, input int cnt, input bit en);
      return {en, 7'd0, 8'(iv), 8'd0, 8'(cnt)};
   endfunction

   task automatic do_poll(input logic [19:0] addr, input logic [31:0] expv,
                          input logic [31:0] good, input logic [31:0] bad,
                          input int nfail, output int reads, output bit ok,
                          output bit got);
      @(negedge clk); ins_valid = 1; ins_hi = {8'h0A, 4'h0, addr}; ins_lo = expv;
      @(negedge clk); ins_valid = 0;
      got = 0; reads = 0; ok = 0;
      for (int i = 0; i < 2000 && !got; i++) begin
         rd_ack = 0; us_tick = 0;
         if (done) begin
            got = 1; ok = done_ok;
         end else if (rd_req) begin
            if (rd_addr !== addr) addr_err++;
            rd_ack = 1; rd_data = (reads < nfail) ? bad : good; reads++;
         end else begin
            us_tick = 1;
         end
         if (!got) @(negedge clk);
      end
      rd_ack = 0; us_tick = 0;
   endtask

   initial begin
      #1000000;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int rd; bit ok, got;
      logic [31:0] mask, expv, good, bad;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 rd_req", rd_req, 0);
      chk("R1 done", done, 0);
      chk("R1 irq_err", irq_err, 0);

      // R1/R5: reset function word is disabled -> immediate pass, no read
      do_poll(20'h00100, 32'h0, 32'h0, 32'h1, 0, rd, ok, got);
      chk("R5 reset disabled reads", rd, 0);
      chk("R5 reset disabled ok", {got, ok}, 2'b11);

      mask = 32'h00FF_FF00; expv = 32'h1234_5678;
      good = (expv & mask) | (~expv & ~mask);
      bad  = good ^ 32'h0000_0100;
      cfg_write(0, mask);
      steps(5);

      // R6/R7/R4/R8 sweep over count, interval and number of failing reads
      for (int cnt = 0; cnt < 4; cnt++)
         for (int iv = 0; iv < 3; iv++) begin
            cfg_write(1, fword(iv, cnt, 1));
            steps(5);
            for (int nf = 0; nf < 5; nf++) begin
               int exp_reads; bit exp_ok;
               exp_ok = (nf <= cnt);
               exp_reads = exp_ok ? nf + 1 : cnt + 1;
               do_poll(20'(20'hA5000 + nf), expv, good, bad, nf, rd, ok, got);
               chk("R6 sweep reads", rd, exp_reads);
               chk("R4 R6 sweep outcome", {got, ok}, {1'b1, exp_ok});
               chk("R8 irq after poll", irq_err, !exp_ok);
               if (!exp_ok) begin
                  @(negedge clk); err_clr = 1;
                  @(negedge clk); err_clr = 0;
                  chk("R8 irq cleared", irq_err, 0);
               end
            end
         end
      chk("R3 read address", addr_err, 0);

      // R8: irq sticky without clear
      cfg_write(1, fword(0, 0, 1)); steps(5);
      do_poll(20'h1, expv, good, bad, 1, rd, ok, got);
      repeat (4) @(negedge clk);
      chk("R8 irq sticky", irq_err, 1);
      @(negedge clk); err_clr = 1;
      @(negedge clk); err_clr = 0;
      chk("R8 irq clear", irq_err, 0);

      // R7: exact wait interval of 3 ticks
      cfg_write(1, fword(3, 1, 1)); steps(5);
      @(negedge clk); ins_valid = 1; ins_hi = 32'h0A00_0042; ins_lo = expv;
      @(negedge clk); ins_valid = 0;
      chk("R7 first read immediate", rd_req, 1);
      rd_ack = 1; rd_data = bad;
      @(negedge clk); rd_ack = 0;
      repeat (4) @(negedge clk);
      chk("R7 no read without ticks", rd_req, 0);
      us_tick = 1; @(negedge clk); @(negedge clk);
      us_tick = 0; @(negedge clk);
      chk("R7 no read after 2 ticks", rd_req, 0);
      us_tick = 1; @(negedge clk); us_tick = 0;
      chk("R7 read after 3rd tick", rd_req, 1);
      // R10: second instruction while busy is ignored
      ins_valid = 1; ins_hi = 32'h0A00_0077;
      @(negedge clk); ins_valid = 0;
      chk("R10 addr kept while busy", rd_addr, 20'h42);
      rd_ack = 1; rd_data = good;
      @(negedge clk); rd_ack = 0;
      chk("R4 pass after retry", {done, done_ok}, 2'b11);
      repeat (3) @(negedge clk);
      chk("R10 no second poll", {rd_req, busy}, 2'b00);

      // R2: other opcode ignored
      @(negedge clk); ins_valid = 1; ins_hi = 32'h0100_0042;
      @(negedge clk); ins_valid = 0;
      chk("R2 no req for other opcode", {rd_req, done, busy}, 3'b000);
      @(negedge clk);
      chk("R2 still idle", {rd_req, done, busy}, 3'b000);

      // R4: bits outside mask ignored, masked bit change fails
      cfg_write(1, fword(0, 0, 1)); steps(5);
      do_poll(20'h3, expv, expv ^ 32'hFF00_00FF, bad, 0, rd, ok, got);
      chk("R4 unmasked bits ignored", {got, ok}, 2'b11);
      do_poll(20'h3, expv, expv ^ 32'h0001_0000, bad, 0, rd, ok, got);
      chk("R4 masked bit mismatch", {got, ok}, 2'b10);
      @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;

      // R9: settle gap - new function word not used before 5 steps
      cfg_write(1, fword(0, 0, 0));
      steps(4);
      do_poll(20'h9, expv, good, bad, 0, rd, ok, got);
      chk("R9 old config inside gap", rd, 1);
      steps(1);
      do_poll(20'h9, expv, good, bad, 0, rd, ok, got);
      chk("R9 new config after gap", rd, 0);
      chk("R5 disabled pass", {got, ok}, 2'b11);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule